// File: doc/BRIEF.md
# Packed Half-Precision Compare into Predicate Flags

This unit compares two packed pairs of IEEE half-precision numbers lane by lane under one selectable condition. The two per-lane outcomes are folded into a single boolean, either by AND or by OR. That boolean is then merged with a source flag, taken from a small predicate register file, through a selectable logic operation.

Each accepted request writes two flags back into the same file. The primary flag receives the merged result. The secondary flag receives the same merge applied to the inverted fold. Both writes land on the rising edge that samples the request, so the new flag values are visible one cycle after the strobe. The operands are expected to be already swizzled, negated or made absolute by upstream logic. Denormal flushing is not performed.

The file holds eight one-bit entries. Entry 7 is a fixed true flag that no write can alter. All eight entries are presented on one output bus.

Top module: `pcmp_pred_unit`

## Requirements
- R1: After reset, entries 0 to 6 are 0 and `pred_bits` equals 8'h80; bit 7 of `pred_bits` is 1 at all times.
- R2: Lane 0 occupies bits [15:0] and lane 1 bits [31:16] of each operand. When neither value of a lane is NaN, the lane result is `cond[0]&(a<b) | cond[1]&(a==b) | cond[2]&(a>b)`. This makes codes 1..6 mean LT, EQ, LE, GT, NE, GE, makes code 7 mean "ordered", and treats +0 and -0 as equal.
- R3: A value is NaN when its exponent field [14:10] is all ones and its mantissa [9:0] is nonzero. When either value of a lane is NaN, the lane result equals `cond[3]`, so codes 0..7 give false, codes 8..15 give true, code 0 is always false and code 15 is always true.
- R4: With `lane_and`=1 the fold is lane0 AND lane1; with `lane_and`=0 it is lane0 OR lane1.
- R5: The source flag is `pred_bits[src_sel]` XOR `src_inv`, read from the file state before the write of the same request.
- R6: `bool_op` encodes 0 = AND, 1 = OR, 2 = XOR; code 3 acts as AND.
- R7: With `in_valid` high at a rising edge, entry `pri_dst` holds (fold OP source) from that edge on.
- R8: At the same edge, entry `sec_dst` holds ((NOT fold) OP source); when `sec_dst`=7 no secondary write happens.
- R9: A write aimed at entry 7 is dropped; a request with `pri_dst`=7 changes no entry through its primary write.
- R10: When `pri_dst` equals `sec_dst` (not 7), the entry takes the primary value.
- R11: While `in_valid` is low, no entry changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| opa | input | 32 | Packed first operands, lane 1 high |
| opb | input | 32 | Packed second operands, lane 1 high |
| cond | input | 4 | Compare condition code |
| lane_and | input | 1 | 1 = AND the lanes, 0 = OR them |
| src_sel | input | 3 | Index of the source flag |
| src_inv | input | 1 | Invert the source flag |
| bool_op | input | 2 | Merge operation select |
| pri_dst | input | 3 | Primary destination index |
| sec_dst | input | 3 | Secondary destination index, 7 = none |
| pred_bits | output | 8 | Registered predicate file, bit 7 fixed at 1 |

## Verification
A corrupted flag entry shows on `pred_bits` on the very next cycle, since the whole file is exposed. It also spreads into later results whenever that entry is chosen as the source flag. A wrong lane relation, NaN detect or fold choice shows as a wrong bit in the destination entry one cycle after the strobe. A faulty write-enable or collision priority shows as a neighbour entry changing, or not changing, at that same edge. For that reason every request is followed by a comparison of all eight bits, not only the addressed ones.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  localparam int COND_W = 4;
  localparam int OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    BOP_AND = 2'd0,
    BOP_OR  = 2'd1,
    BOP_XOR = 2'd2,
    BOP_RSV = 2'd3
  } bool_op_e;

  function automatic logic apply_op(input logic [OP_W-1:0] op, input logic x, input logic y);
    case (bool_op_e'(op))
      BOP_OR:  return x | y;
      BOP_XOR: return x ^ y;
      default: return x & y;
    endcase
  endfunction
endpackage

// File: rtl/pcmp_lane.sv
module pcmp_lane
  import pcmp_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int EXP_W  = 5
) (
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  input  logic [COND_W-1:0] cond,
  output logic              hit
);
  localparam int MAN_W = HALF_W - 1 - EXP_W;

  logic a_nan, b_nan, unord, both_zero;
  logic [HALF_W-1:0] key_a, key_b;
  logic lt, eq, gt;

  always_comb begin
    a_nan     = (&a[HALF_W-2:MAN_W]) && (|a[MAN_W-1:0]);
    b_nan     = (&b[HALF_W-2:MAN_W]) && (|b[MAN_W-1:0]);
    unord     = a_nan || b_nan;
    both_zero = ~(|a[HALF_W-2:0]) && ~(|b[HALF_W-2:0]);
    // Map to an unsigned ordering key: negatives reversed below positives.
    key_a = a[HALF_W-1] ? ~a : {1'b1, a[HALF_W-2:0]};
    key_b = b[HALF_W-1] ? ~b : {1'b1, b[HALF_W-2:0]};
    lt = !both_zero && (key_a < key_b);
    gt = !both_zero && (key_a > key_b);
    eq = both_zero || (key_a == key_b);
    hit = unord ? cond[COND_W-1] : |(cond[2:0] & {gt, eq, lt});
  end

  always_comb begin
    if (!unord) begin
      AST_ONE_RELATION: assert ($countones({lt, eq, gt}) == 1); // R2
    end
  end
endmodule

// File: rtl/pcmp_merge.sv
module pcmp_merge
  import pcmp_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] lane_hit,
  input  logic             lane_and,
  input  logic             src_bit,
  input  logic             src_inv,
  input  logic [OP_W-1:0]  bool_op,
  output logic             pri_val,
  output logic             sec_val
);
  logic fold, src;

  always_comb begin
    fold    = lane_and ? (&lane_hit) : (|lane_hit);
    src     = src_bit ^ src_inv;
    pri_val = apply_op(bool_op, fold, src);
    sec_val = apply_op(bool_op, !fold, src);
  end

  always_comb begin
    if (bool_op == BOP_XOR) begin
      AST_XOR_SPLIT: assert (pri_val != sec_val); // R8
    end
  end
endmodule

// File: rtl/pcmp_pred_file.sv
module pcmp_pred_file #(
  parameter int PRED_N = 8,
  localparam int IDX_W = $clog2(PRED_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pri_we,
  input  logic [IDX_W-1:0]  pri_idx,
  input  logic              pri_val,
  input  logic              sec_we,
  input  logic [IDX_W-1:0]  sec_idx,
  input  logic              sec_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_bit,
  output logic [PRED_N-1:0] bits
);
  logic [PRED_N-2:0] store;

  genvar gi;
  generate
    for (gi = 0; gi < PRED_N - 1; gi++) begin : g_entry
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
      always_ff @(posedge clk) begin
        if (rst) begin
          store[gi] <= 1'b0;
        end else if (pri_we && pri_idx == MY_IDX) begin
          store[gi] <= pri_val;
        end else if (sec_we && sec_idx == MY_IDX) begin
          store[gi] <= sec_val;
        end
      end
    end
  endgenerate

  assign bits   = {1'b1, store};
  assign rd_bit = bits[rd_idx];

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (store == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pri_we && !sec_we) |=> $stable(store)); // R11
endmodule

// File: rtl/pcmp_pred_unit.sv
module pcmp_pred_unit
  import pcmp_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int HALF_W = 16,
  parameter int PRED_N = 8,
  localparam int IDX_W  = $clog2(PRED_N),
  localparam int PAIR_W = LANES * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PAIR_W-1:0] opa,
  input  logic [PAIR_W-1:0] opb,
  input  logic [COND_W-1:0] cond,
  input  logic              lane_and,
  input  logic [IDX_W-1:0]  src_sel,
  input  logic              src_inv,
  input  logic [OP_W-1:0]   bool_op,
  input  logic [IDX_W-1:0]  pri_dst,
  input  logic [IDX_W-1:0]  sec_dst,
  output logic [PRED_N-1:0] pred_bits
);
  localparam logic [IDX_W-1:0] TRUE_IDX = IDX_W'(PRED_N - 1);

  logic [LANES-1:0] lane_hit;
  logic src_bit, pri_val, sec_val, pri_we, sec_we;

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      pcmp_lane #(.HALF_W(HALF_W)) u_lane (
        .a    (opa[gl*HALF_W +: HALF_W]),
        .b    (opb[gl*HALF_W +: HALF_W]),
        .cond (cond),
        .hit  (lane_hit[gl])
      );
    end
  endgenerate

  pcmp_merge #(.LANES(LANES)) u_merge (
    .lane_hit (lane_hit),
    .lane_and (lane_and),
    .src_bit  (src_bit),
    .src_inv  (src_inv),
    .bool_op  (bool_op),
    .pri_val  (pri_val),
    .sec_val  (sec_val)
  );

  assign pri_we = in_valid && (pri_dst != TRUE_IDX);
  assign sec_we = in_valid && (sec_dst != TRUE_IDX);

  pcmp_pred_file #(.PRED_N(PRED_N)) u_file (
    .clk     (clk),
    .rst     (rst),
    .pri_we  (pri_we),
    .pri_idx (pri_dst),
    .pri_val (pri_val),
    .sec_we  (sec_we),
    .sec_idx (sec_dst),
    .sec_val (sec_val),
    .rd_idx  (src_sel),
    .rd_bit  (src_bit),
    .bits    (pred_bits)
  );

  AST_PRI_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pri_dst != TRUE_IDX) |=> (pred_bits[$past(pri_dst)] == $past(pri_val))); // R7
  AST_SEC_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sec_dst != TRUE_IDX && sec_dst != pri_dst)
      |=> (pred_bits[$past(sec_dst)] == $past(sec_val))); // R8
  AST_TRUE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> pred_bits[TRUE_IDX]); // R9
  AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pred_bits)); // R11
endmodule

// File: tb/pcmp_pred_unit_tb.sv
module pcmp_pred_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0]  cond = '0;
  logic        lane_and = 1'b0;
  logic [2:0]  src_sel = '0;
  logic        src_inv = 1'b0;
  logic [1:0]  bool_op = '0;
  logic [2:0]  pri_dst = '0, sec_dst = 3'd7;
  logic [7:0]  pred_bits;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl = 8'h80;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  pcmp_pred_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .cond(cond), .lane_and(lane_and), .src_sel(src_sel), .src_inv(src_inv),
    .bool_op(bool_op), .pri_dst(pri_dst), .sec_dst(sec_dst), .pred_bits(pred_bits)
  );

  always #2 clk = ~clk;

  function automatic logic is_nan(input logic [15:0] h);
    return (h[14:10] == 5'h1f) && (h[9:0] != 0);
  endfunction

  function automatic real h2r(input logic [15:0] h);
    real v;
    int  e;
    e = int'(h[14:10]);
    if (e == 0) v = real'(h[9:0]) / 16777216.0;
    else if (e == 31) v = 1.0e30;
    else begin
      v = real'(1024 + int'(h[9:0]));
      for (int k = 0; k < e; k++) v = v * 2.0;
      for (int k = 0; k < 25; k++) v = v / 2.0;
    end
    return h[15] ? -v : v;
  endfunction

  function automatic logic ref_lane(input logic [15:0] a, input logic [15:0] b, input logic [3:0] c);
    real ra, rb;
    if (is_nan(a) || is_nan(b)) return c[3];
    ra = h2r(a);
    rb = h2r(b);
    case (c[2:0])
      3'd0: return 1'b0;
      3'd1: return ra < rb;
      3'd2: return ra == rb;
      3'd3: return ra <= rb;
      3'd4: return ra > rb;
      3'd5: return ra != rb;
      3'd6: return ra >= rb;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic ref_op(input logic [1:0] o, input logic x, input logic y);
    if (o == 2'd1) return x | y;
    if (o == 2'd2) return x ^ y;
    return x & y;
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c,
                       input logic la, input logic [2:0] ss, input logic si,
                       input logic [1:0] o, input logic [2:0] pd, input logic [2:0] sd,
                       input string tag);
    logic l0, l1, f, s;
    logic [7:0] nxt;
    @(negedge clk);
    opa = a; opb = b; cond = c; lane_and = la; src_sel = ss; src_inv = si;
    bool_op = o; pri_dst = pd; sec_dst = sd; in_valid = 1'b1;
    l0 = ref_lane(a[15:0], b[15:0], c);
    l1 = ref_lane(a[31:16], b[31:16], c);
    f = la ? (l0 & l1) : (l0 | l1);
    s = mdl[ss] ^ si;
    nxt = mdl;
    if (sd != 3'd7) nxt[sd] = ref_op(o, !f, s);
    if (pd != 3'd7) nxt[pd] = ref_op(o, f, s);
    mdl = nxt;
    exp_q.push_back(mdl);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    opa = $urandom; opb = $urandom; cond = 4'($urandom);
    src_sel = 3'($urandom); src_inv = 1'b1; bool_op = 2'($urandom);
    pri_dst = 3'($urandom); sec_dst = 3'($urandom); lane_and = 1'($urandom);
    exp_q.push_back(mdl);
    tag_q.push_back(tag);
  endtask

  // Monitor: each edge with a pending item is checked at the following falling edge.
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (pred_bits !== e) begin
          bad++;
          $display("FAIL %s pred_bits actual=%h expected=%h", t, pred_bits, e);
        end
      end
    end
  end

  function automatic logic [15:0] pick();
    logic [15:0] tbl[12];
    tbl = '{16'h0000, 16'h8000, 16'h3c00, 16'hbc00, 16'h4000, 16'hc000,
            16'h7c00, 16'hfc00, 16'h7e00, 16'h0001, 16'h7bff, 16'h3800};
    if ($urandom % 3 == 0) return 16'($urandom);
    return tbl[$urandom % 12];
  endfunction

  initial begin
    #(4 * 50000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    total++;
    if (pred_bits !== 8'h80) begin
      bad++;
      $display("FAIL R1 reset actual=%h expected=80", pred_bits);
    end

    // R2: all codes over ordered pairs (equal, less, greater, signed zeros, infinities)
    for (int c = 0; c < 16; c++) begin
      issue({16'h4000, 16'h3c00}, {16'h3c00, 16'h3c00}, 4'(c), 1'b0, 3'd7, 1'b0, 2'd0, 3'(c % 7), 3'd7, "R2");
      issue({16'hc000, 16'h8000}, {16'hbc00, 16'h0000}, 4'(c), 1'b1, 3'd7, 1'b0, 2'd0, 3'(c % 7), 3'd7, "R2");
      issue({16'h7c00, 16'h0001}, {16'hfc00, 16'h0000}, 4'(c), 1'b1, 3'd7, 1'b0, 2'd0, 3'((c + 3) % 7), 3'd7, "R2");
    end
    // R3: NaN in one lane or both
    for (int c = 0; c < 16; c++) begin
      issue({16'h7e00, 16'h3c00}, {16'h3c00, 16'h7c01}, 4'(c), 1'b1, 3'd7, 1'b0, 2'd0, 3'(c % 7), 3'd7, "R3");
      issue({16'h3c00, 16'hfe00}, {16'h3c00, 16'h3c00}, 4'(c), 1'b0, 3'd7, 1'b0, 2'd0, 3'(c % 7), 3'd7, "R3");
    end
    // R4: lanes disagree, AND vs OR
    issue({16'h3c00, 16'h4000}, {16'h3c00, 16'h3c00}, 4'd2, 1'b1, 3'd7, 1'b0, 2'd0, 3'd1, 3'd7, "R4");
    issue({16'h3c00, 16'h4000}, {16'h3c00, 16'h3c00}, 4'd2, 1'b0, 3'd7, 1'b0, 2'd0, 3'd2, 3'd7, "R4");
    // R5/R6: source flag from a written entry, with invert, every operation
    issue(32'h0, 32'h0, 4'd15, 1'b0, 3'd7, 1'b0, 2'd0, 3'd3, 3'd4, "R5");
    for (int o = 0; o < 4; o++) begin
      issue(32'h0, 32'h0, 4'd0, 1'b0, 3'd3, 1'b0, 2'(o), 3'd0, 3'd7, "R6");
      issue(32'h0, 32'h0, 4'd15, 1'b0, 3'd4, 1'b1, 2'(o), 3'd1, 3'd2, "R6");
      issue(32'h0, 32'h0, 4'd0, 1'b1, 3'd7, 1'b1, 2'(o), 3'd5, 3'd6, "R5");
    end
    // R7: back-to-back dependency through the source flag
    issue(32'h0, 32'h0, 4'd15, 1'b0, 3'd7, 1'b0, 2'd0, 3'd2, 3'd7, "R7");
    issue(32'h0, 32'h0, 4'd15, 1'b0, 3'd2, 1'b1, 2'd0, 3'd3, 3'd7, "R7");
    // R8: secondary write, and suppression at index 7
    issue(32'h0, 32'h0, 4'd0, 1'b0, 3'd7, 1'b0, 2'd1, 3'd0, 3'd6, "R8");
    issue(32'h0, 32'h0, 4'd15, 1'b0, 3'd7, 1'b0, 2'd0, 3'd1, 3'd7, "R8");
    // R9: primary aimed at the fixed entry
    issue(32'h0, 32'h0, 4'd0, 1'b0, 3'd7, 1'b0, 2'd0, 3'd7, 3'd7, "R9");
    issue(32'h0, 32'h0, 4'd0, 1'b0, 3'd7, 1'b0, 2'd1, 3'd7, 3'd5, "R9");
    // R10: same destination for both writes
    issue(32'h0, 32'h0, 4'd15, 1'b0, 3'd7, 1'b0, 2'd0, 3'd4, 3'd4, "R10");
    issue(32'h0, 32'h0, 4'd0, 1'b0, 3'd7, 1'b0, 2'd0, 3'd4, 3'd4, "R10");
    // R11: idle cycles with busy inputs
    for (int k = 0; k < 6; k++) idle("R11");
    // R7: mixed random traffic
    for (int k = 0; k < 400; k++) begin
      issue({pick(), pick()}, {pick(), pick()}, 4'($urandom), 1'($urandom), 3'($urandom),
            1'($urandom), 2'($urandom), 3'($urandom), 3'($urandom), "R7");
      if (k % 9 == 0) idle("R11");
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule